// File: doc/BRIEF.md
# Double-Buffered Time-Slot Interchange Switch

This block reorders the bytes of a framed byte stream. A switching frame is a fixed number of byte timeslots (270 by default), and a frame pulse marks timeslot 0. Two input buses, A and B, each feed a private two-page data memory. During every timeslot the incoming byte of each bus is stored at the current timeslot's address in the page being filled. At the same time, the other page, filled during the previous frame, is read at an address chosen by the connection entry for the current timeslot. The two pages trade roles on every frame pulse.

A single table of connection entries, one per timeslot, controls both memories and the output. Each entry picks one of four sources for the output byte of its timeslot: a byte from memory A, a byte from memory B, the byte on a bypass bus in the same timeslot, or a fixed idle byte held in the entry itself. An all-ones idle byte, for example, serves as an alarm-indication fill. An entry can also leave the timeslot unclaimed, so that a neighbouring element can drive the shared output. In that case the output enable stays low and the data output is zero. The output is registered, so every result appears one clock after the timeslot that produced it. Entries are loaded through a simple write port and take effect the next time their timeslot comes around.

Top module: `tsi_switch`

## Requirements
- R1: A high `fp_i` makes the current timeslot 0. Without a pulse the timeslot advances by one each clock and wraps from SLOTS-1 to 0. Every entry-controlled output is produced for the timeslot counted this way.
- R2: An entry with bit 11 = 1, bits [10:9] = 0 (memory A) and address field [8:0] = n < SLOTS drives `dout_o` with the byte that `a_i` carried in timeslot n of the previous frame, one clock after its own timeslot, with `oe_o` high. The pages swap on every frame pulse.
- R3: Bits [10:9] = 1 (memory B) behaves the same way, using the bytes of `b_i`. Both memories are written in every timeslot, whatever the entries select.
- R4: Bits [10:9] = 2 (bypass) drives `dout_o` with the `byp_i` byte of the same timeslot, one clock later, with `oe_o` high.
- R5: Bits [10:9] = 3 (idle) drives `dout_o` with entry bits [7:0], one clock after the timeslot, with `oe_o` high.
- R6: An entry with bit 11 = 0 leaves the timeslot unclaimed: one clock later `oe_o` is low and `dout_o` is zero. Whenever `oe_o` is low, `dout_o` is zero.
- R7: After reset every entry is unclaimed, so `oe_o` and `dout_o` are low until entries are written.
- R8: A memory-read entry whose address field is SLOTS or above yields a zero byte with `oe_o` high.
- R9: Writing the entry for slot k with `cfg_we_i` changes the output of slot k from the next occurrence of slot k onward. The entries of all other slots keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one timeslot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame pulse, high in timeslot 0 |
| a_i | input | 8 | Input bus A byte of the current timeslot |
| b_i | input | 8 | Input bus B byte of the current timeslot |
| byp_i | input | 8 | Bypass bus byte of the current timeslot |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_slot_i | input | 9 | Timeslot whose entry is written |
| cfg_entry_i | input | 12 | Entry: [11] claim, [10:9] source, [8:0] address or idle byte |
| dout_o | output | 8 | Registered output byte |
| oe_o | output | 1 | Registered output enable |

## Verification
The bench programs a full table that mixes all four sources and unclaimed slots. Memory reads include addresses 0 and SLOTS-1 and one address beyond the frame. A page swap that is missing or in the wrong direction would return bytes from the current frame instead of the previous one, and would fail the checks on memories A and B. The bench then rewrites one entry during live traffic. A design that applies the write one frame late, or disturbs neighbouring entries, would fail R9. A short frame followed by an early frame pulse tests the counter re-alignment: a counter that ignored the pulse would place idle and bypass bytes in the wrong slots.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

   typedef enum logic [1:0] {
      SRC_MEM_A = 2'd0,
      SRC_MEM_B = 2'd1,
      SRC_BYP   = 2'd2,
      SRC_IDLE  = 2'd3
   } tsi_src_e;

   localparam int NUM_MEMS = 2;

   function automatic int field_width(input int addr_w, input int data_w);
      return (addr_w > data_w) ? addr_w : data_w;
   endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer #(
   parameter int SLOTS  = 270,
   parameter int ADDR_W = $clog2(SLOTS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fp_i,
   output logic [ADDR_W-1:0] slot_o,
   output logic              page_o
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SLOTS - 1);

   logic [ADDR_W-1:0] cnt_q;
   logic              page_q;

   always_comb begin
      if (fp_i) begin
         slot_o = '0;
         page_o = ~page_q;
      end else begin
         slot_o = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         page_o = page_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= LAST;
         page_q <= 1'b0;
      end else begin
         cnt_q  <= slot_o;
         page_q <= page_o;
      end
   end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
   parameter int DATA_W = 8,
   parameter int SLOTS  = 270,
   parameter int ADDR_W = $clog2(SLOTS)
) (
   input  logic              clk_i,
   input  logic              wr_page_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SLOTS - 1);

   logic [DATA_W-1:0] mem_q [2][SLOTS];

   always_ff @(posedge clk_i) begin
      mem_q[wr_page_i][wr_addr_i] <= wr_data_i;
   end

   always_comb begin
      if (rd_addr_i <= LAST) rd_data_o = mem_q[~wr_page_i][rd_addr_i];
      else                   rd_data_o = '0;
   end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
   parameter int SLOTS  = 270,
   parameter int ADDR_W = $clog2(SLOTS),
   parameter int ENT_W  = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] wslot_i,
   input  logic [ENT_W-1:0]  wentry_i,
   input  logic [ADDR_W-1:0] rslot_i,
   output logic [ENT_W-1:0]  rentry_o
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SLOTS - 1);

   logic [ENT_W-1:0] tab_q [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                    tab_q[g] <= '0;
         else if (we_i && wslot_i == ADDR_W'(g))         tab_q[g] <= wentry_i;
      end
   end

   always_comb begin
      if (rslot_i <= LAST) rentry_o = tab_q[rslot_i];
      else                 rentry_o = '0;
   end

endmodule

// File: rtl/tsi_out_mux.sv
module tsi_out_mux
   import tsi_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int FIELD_W = 9
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               claim_i,
   input  tsi_src_e           src_i,
   input  logic [FIELD_W-1:0] field_i,
   input  logic [DATA_W-1:0]  mem_a_i,
   input  logic [DATA_W-1:0]  mem_b_i,
   input  logic [DATA_W-1:0]  byp_i,
   output logic [DATA_W-1:0]  dout_o,
   output logic               oe_o
);
   logic [DATA_W-1:0] pick;

   always_comb begin
      unique case (src_i)
         SRC_MEM_A: pick = mem_a_i;
         SRC_MEM_B: pick = mem_b_i;
         SRC_BYP:   pick = byp_i;
         default:   pick = field_i[DATA_W-1:0];
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dout_o <= '0;
         oe_o   <= 1'b0;
      end else begin
         dout_o <= claim_i ? pick : '0;
         oe_o   <= claim_i;
      end
   end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
   import tsi_pkg::*;
#(
   parameter int  DATA_W  = 8,
   parameter int  SLOTS   = 270,
   localparam int ADDR_W  = $clog2(SLOTS),
   localparam int FIELD_W = tsi_pkg::field_width(ADDR_W, DATA_W),
   localparam int ENT_W   = FIELD_W + 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fp_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] byp_i,
   input  logic              cfg_we_i,
   input  logic [ADDR_W-1:0] cfg_slot_i,
   input  logic [ENT_W-1:0]  cfg_entry_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              oe_o
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("tsi_switch: SLOTS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("tsi_switch: DATA_W must be at least 1");
   end

   logic [ADDR_W-1:0]  cur_slot;
   logic               wr_page;
   logic [ENT_W-1:0]   ent;
   logic               ent_claim;
   tsi_src_e           ent_src;
   logic [FIELD_W-1:0] ent_field;
   logic [DATA_W-1:0]  in_bus  [NUM_MEMS];
   logic [DATA_W-1:0]  rd_data [NUM_MEMS];

   tsi_slot_timer #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) timer_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fp_i   (fp_i),
      .slot_o (cur_slot),
      .page_o (wr_page)
   );

   tsi_conn_mem #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .ENT_W(ENT_W)) conn_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cfg_we_i),
      .wslot_i  (cfg_slot_i),
      .wentry_i (cfg_entry_i),
      .rslot_i  (cur_slot),
      .rentry_o (ent)
   );

   assign ent_claim = ent[ENT_W-1];
   assign ent_src   = tsi_src_e'(ent[ENT_W-2 -: 2]);
   assign ent_field = ent[FIELD_W-1:0];

   assign in_bus[0] = a_i;
   assign in_bus[1] = b_i;

   for (genvar m = 0; m < NUM_MEMS; m++) begin : g_mem
      tsi_data_mem #(.DATA_W(DATA_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) mem_i (
         .clk_i     (clk_i),
         .wr_page_i (wr_page),
         .wr_addr_i (cur_slot),
         .wr_data_i (in_bus[m]),
         .rd_addr_i (ent_field[ADDR_W-1:0]),
         .rd_data_o (rd_data[m])
      );
   end

   tsi_out_mux #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) mux_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .claim_i (ent_claim),
      .src_i   (ent_src),
      .field_i (ent_field),
      .mem_a_i (rd_data[0]),
      .mem_b_i (rd_data[1]),
      .byp_i   (byp_i),
      .dout_o  (dout_o),
      .oe_o    (oe_o)
   );

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
   parameter int  DATA_W  = 8,
   parameter int  SLOTS   = 270,
   localparam int ADDR_W  = $clog2(SLOTS),
   localparam int FIELD_W = tsi_pkg::field_width(ADDR_W, DATA_W),
   localparam int ENT_W   = FIELD_W + 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              fp_i,
   input logic [DATA_W-1:0] byp_i,
   input logic [ADDR_W-1:0] cur_slot,
   input logic              wr_page,
   input logic [ENT_W-1:0]  ent,
   input logic [DATA_W-1:0] dout_o,
   input logic              oe_o
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SLOTS - 1);

   logic seen_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= 1'b1;
   end

   assert_slot_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q |-> fp_i || cur_slot == (($past(cur_slot) == LAST) ? '0 : $past(cur_slot) + 1'b1));

   assert_page_swap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && fp_i) |-> wr_page != $past(wr_page));

   assert_page_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !fp_i) |-> wr_page == $past(wr_page));

   assert_bypass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ent[ENT_W-1] && ent[ENT_W-2 -: 2] == 2'd2) |=> oe_o && dout_o == $past(byp_i));

   assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ent[ENT_W-1] && ent[ENT_W-2 -: 2] == 2'd3) |=> oe_o && dout_o == $past(ent[DATA_W-1:0]));

   assert_unclaimed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ent[ENT_W-1] |=> !oe_o && dout_o == '0);

   assert_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_o |-> dout_o == '0);

endmodule

bind tsi_switch tsi_switch_chk #(.DATA_W(DATA_W), .SLOTS(SLOTS)) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .fp_i     (fp_i),
   .byp_i    (byp_i),
   .cur_slot (cur_slot),
   .wr_page  (wr_page),
   .ent      (ent),
   .dout_o   (dout_o),
   .oe_o     (oe_o)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SL = 270;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fp = 1'b0;
   logic [7:0]  a = '0, b = '0, byp = '0;
   logic        cfg_we = 1'b0;
   logic [8:0]  cfg_slot = '0;
   logic [11:0] cfg_entry = '0;
   logic [7:0]  dout;
   logic        oe;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tsi_switch dut_i (
      .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .a_i(a), .b_i(b), .byp_i(byp),
      .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_entry_i(cfg_entry),
      .dout_o(dout), .oe_o(oe)
   );

   typedef struct {
      bit          chk;
      bit          oe;
      logic [7:0]  d;
      string       tag;
      int          slot;
   } exp_t;

   exp_t exp_q[$];

   int m_en [SL];
   int m_sel[SL];
   int m_fld[SL];

   function automatic logic [7:0] fa(int f, int s);   return 8'((f * 37) + (s * 3) + 1);  endfunction
   function automatic logic [7:0] fb(int f, int s);   return 8'((f * 11) ^ (s * 7) ^ 92);  endfunction
   function automatic logic [7:0] fbp(int f, int s);  return 8'(s ^ (f * 90));             endfunction

   task automatic check(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic write_entry(int k, int en, int sel, int fld);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_slot  = 9'(k);
      cfg_entry = {1'(en), 2'(sel), 9'(fld)};
      m_en[k] = en; m_sel[k] = sel; m_fld[k] = fld;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drive one timeslot and push its expected output
   task automatic drive_slot(int f, int s, bit pulse, bit score_mem, string other_tag);
      exp_t e;
      bit   is_mem;
      @(negedge clk);
      fp  = pulse;
      a   = fa(f, s);
      b   = fb(f, s);
      byp = fbp(f, s);
      e.slot = s;
      is_mem = (m_en[s] != 0) && (m_sel[s] < 2);
      if (m_en[s] == 0) begin
         e.oe = 1'b0; e.d = 8'h00; e.tag = (other_tag != "") ? other_tag : "R6";
      end else if (m_sel[s] == 0) begin
         e.oe = 1'b1;
         e.d  = (m_fld[s] < SL) ? fa(f - 1, m_fld[s]) : 8'h00;
         e.tag = (m_fld[s] < SL) ? "R2" : "R8";
      end else if (m_sel[s] == 1) begin
         e.oe = 1'b1; e.d = fb(f - 1, m_fld[s]); e.tag = "R3";
      end else if (m_sel[s] == 2) begin
         e.oe = 1'b1; e.d = fbp(f, s); e.tag = (other_tag != "") ? other_tag : "R4";
      end else begin
         e.oe = 1'b1; e.d = 8'(m_fld[s]); e.tag = (other_tag != "") ? other_tag : "R5";
      end
      e.chk = is_mem ? score_mem : 1'b1;
      exp_q.push_back(e);
   endtask

   // monitor: the output of a slot appears after the edge that follows its drive
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.chk) begin
               check(oe === e.oe, e.tag, $sformatf("oe slot %0d", e.slot), int'(oe), int'(e.oe));
               check(dout === e.d, e.tag, $sformatf("data slot %0d", e.slot), int'(dout), int'(e.d));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < SL; k++) begin m_en[k] = 0; m_sel[k] = 0; m_fld[k] = 0; end

      // R7: reset state and unclaimed table after release
      repeat (3) @(negedge clk);
      check(oe === 1'b0 && dout === 8'h00, "R7", "in reset", int'({oe, dout}), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(oe === 1'b0 && dout === 8'h00, "R7", "after reset", int'({oe, dout}), 0);
      end

      // program the table: mix of all sources
      for (int k = 0; k < SL; k++) begin
         case (k % 5)
            0: write_entry(k, 1, 0, (k * 7) % SL);
            1: write_entry(k, 1, 1, SL - 1 - k);
            2: write_entry(k, 1, 2, 0);
            3: write_entry(k, 1, 3, (k & 255) ^ 8'ha5);
            default: write_entry(k, 0, 0, 0);
         endcase
      end
      write_entry(0, 1, 0, SL - 1);   // R2 top address
      write_entry(SL - 1, 1, 0, 0);   // R2 address 0
      write_entry(4, 1, 0, 300);      // R8 address beyond frame
      write_entry(9, 1, 1, SL - 1);   // R3 top address

      // frame 0: memories hold nothing known yet
      for (int s = 0; s < SL; s++) drive_slot(0, s, s == 0, 1'b0, "");
      for (int s = 0; s < SL; s++) drive_slot(1, s, s == 0, 1'b1, "");
      // frame 2 with a live rewrite of slot 2 (R9) during slot 200
      for (int s = 0; s < SL; s++) begin
         drive_slot(2, s, s == 0, 1'b1, "");
         if (s == 200) begin
            cfg_we = 1'b1; cfg_slot = 9'd2; cfg_entry = {1'b1, 2'd3, 9'h0ff};
         end else begin
            cfg_we = 1'b0;
         end
      end
      m_en[2] = 1; m_sel[2] = 3; m_fld[2] = 255;
      // frame 3: slot 2 now idle all-ones (R9), neighbours unchanged
      for (int s = 0; s < SL; s++) drive_slot(3, s, s == 0, 1'b1, (s == 2) ? "R9" : "");

      // R1: short frame then early pulse, non-memory slots must realign
      for (int s = 0; s < 10; s++) drive_slot(4, s, s == 0, 1'b0, "R1");
      for (int s = 0; s < 20; s++) drive_slot(5, s, s == 0, 1'b0, "R1");

      @(negedge clk);
      fp = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule